// File: doc/BRIEF.md
# Serial 5B Symbol Framing Receiver

This block takes a one-bit serial stream, one bit for each clock on which `bit_en` is high. It finds the symbol boundaries in that stream and hands out aligned 5-bit code symbols. A select input chooses the source: either the line input or a serial stream looped back from the local transmitter. A mode input chooses whether that source is decoded from NRZI to NRZ or taken as plain NRZ.

The decoded bits move into a ten-bit window, which holds the two most recent symbols. The block watches this window for three symbol pairs at every bit offset:

- the start-of-frame pair;
- the halt-halt pair;
- the halt-quiet pair.

A match at any offset fixes the symbol boundary at that point and raises a one-clock detection pulse for the pair that matched.

Once the boundary is fixed, the block does two things on a steady cadence:

- It raises a symbol strobe every fifth accepted bit and a pair strobe on every second symbol.
- It decodes each symbol to a 4-bit data value, or flags it as a control or violation code.

Until the first match, no strobes are given.

Top module: `sym_frame_rx`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `aligned`, `sym_valid`, `pair_strobe`, `sof_pulse`, `hh_pulse` and `hq_pulse` are all 0.
- R2: With `nrz_bypass` = 0, each accepted bit becomes 1 when the selected input differs from the previously accepted input bit, and 0 otherwise. The stored previous bit resets to 0.
- R3: With `nrz_bypass` = 1, each accepted input bit enters the window unchanged.
- R4: With `loop_sel` = 1, bits come from `loop_bit` and `line_bit` has no effect. With `loop_sel` = 0, bits come from `line_bit`.
- R5: A bit is accepted only on a clock where `bit_en` = 1. Every strobe and pulse caused by that bit is high for exactly the second clock after the accepting edge, and for no other clock.
- R6: The ten most recent bits 11000 10001 (oldest bit first) raise `sof_pulse`. They also set `aligned` and raise `sym_valid` and `pair_strobe`, with `sym_code` = 10001.
- R7: The pattern 00100 00100 raises `hh_pulse` and aligns in the same way as R6.
- R8: The pattern 00100 00000 raises `hq_pulse` and aligns in the same way as R6.
- R9: While `aligned` = 0, `sym_valid` and `pair_strobe` stay 0.
- R10: Once aligned, `sym_valid` fires after every 5th accepted bit counted from the last pattern match, and `pair_strobe` fires with every 10th. `sym_code` carries the last five bits with the oldest bit in bit 4.
- R11: A pattern match at a new bit offset moves the symbol boundary to that offset.
- R12: The codes 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101 give `sym_data` 0 to 15 in that order with `sym_is_data` = 1 on a strobe. Every other code gives `sym_ctrl` = 1 on a strobe and `sym_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Accept one serial bit this clock |
| line_bit | input | 1 | Serial line input |
| loop_bit | input | 1 | Transmitter-side serial input for loopback |
| loop_sel | input | 1 | 1 selects loop_bit as the source |
| nrz_bypass | input | 1 | 1 passes the source unchanged, 0 decodes NRZI |
| sym_valid | output | 1 | Aligned symbol strobe |
| pair_strobe | output | 1 | Second symbol of a pair completed |
| sym_code | output | 5 | Aligned 5-bit code, oldest bit in bit 4 |
| sym_data | output | 4 | Decoded data value |
| sym_is_data | output | 1 | Strobed symbol is a data code |
| sym_ctrl | output | 1 | Strobed symbol is a control or violation code |
| aligned | output | 1 | Symbol boundary has been found |
| sof_pulse | output | 1 | Start-of-frame pair detected |
| hh_pulse | output | 1 | Halt-halt pair detected |
| hq_pulse | output | 1 | Halt-quiet pair detected |

## Verification
The bench sends stretches of bits in which the symbol boundary has not been found. A design that strobes too early shows spurious symbols before the first start-of-frame pair.

Three extra bits are placed between two start-of-frame pairs. A design that keeps its old phase would then deliver shifted codes.

The sixteen data codes and several control codes are swept under NRZI, NRZ and loopback, with the line input toggling during loopback. A wrong NRZI reference level or a wrong source select corrupts every code. A back-to-back burst checks that no strobe is lost or doubled when `bit_en` has no gaps.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

   typedef struct packed {
      logic       is_data;
      logic [3:0] value;
   } sym_dec_t;

   function automatic sym_dec_t decode_5b(input logic [4:0] code);
      sym_dec_t d;
      d.is_data = 1'b1;
      d.value   = 4'd0;
      case (code)
         5'b11110: d.value = 4'h0;
         5'b01001: d.value = 4'h1;
         5'b10100: d.value = 4'h2;
         5'b10101: d.value = 4'h3;
         5'b01010: d.value = 4'h4;
         5'b01011: d.value = 4'h5;
         5'b01110: d.value = 4'h6;
         5'b01111: d.value = 4'h7;
         5'b10010: d.value = 4'h8;
         5'b10011: d.value = 4'h9;
         5'b10110: d.value = 4'hA;
         5'b10111: d.value = 4'hB;
         5'b11010: d.value = 4'hC;
         5'b11011: d.value = 4'hD;
         5'b11100: d.value = 4'hE;
         5'b11101: d.value = 4'hF;
         default:  d.is_data = 1'b0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/sfr_line_stage.sv
module sfr_line_stage #(
   parameter bit LINE_CODE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic line_bit,
   input  logic loop_bit,
   input  logic loop_sel,
   input  logic nrz_bypass,
   output logic nrz_bit
);
   logic src_bit;
   assign src_bit = loop_sel ? loop_bit : line_bit;

   generate
      if (LINE_CODE_EN) begin : g_nrzi
         logic prev_q;
         always_ff @(posedge clk) begin
            if (rst)         prev_q <= 1'b0;
            else if (bit_en) prev_q <= src_bit;
         end
         assign nrz_bit = nrz_bypass ? src_bit : (src_bit ^ prev_q);
      end else begin : g_plain
         logic unused_mode;
         assign unused_mode = nrz_bypass & bit_en & clk & rst;
         assign nrz_bit = src_bit;
      end
   endgenerate
endmodule

// File: rtl/sfr_window.sv
module sfr_window #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] win_q,
   output logic         fresh_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         win_q   <= '0;
         fresh_q <= 1'b0;
      end else begin
         fresh_q <= shift_en;
         if (shift_en) win_q <= {win_q[W-2:0], din};
      end
   end
endmodule

// File: rtl/sfr_framer.sv
module sfr_framer #(
   parameter int                 SYM_W  = 5,
   parameter logic [2*SYM_W-1:0] PAT_SF = 10'b11000_10001,
   parameter logic [2*SYM_W-1:0] PAT_HH = 10'b00100_00100,
   parameter logic [2*SYM_W-1:0] PAT_HQ = 10'b00100_00000
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               fresh,
   input  logic [2*SYM_W-1:0] win,
   output logic               sym_stb,
   output logic               pair_stb,
   output logic               aligned,
   output logic               sof,
   output logic               hh,
   output logic               hq,
   output logic [SYM_W-1:0]   code
);
   localparam int PAIR_W = 2 * SYM_W;
   localparam int CNT_W  = $clog2(PAIR_W);

   logic [CNT_W-1:0] phase_q;
   logic hit_sf, hit_hh, hit_hq, hit_any;

   assign hit_sf  = (win == PAT_SF);
   assign hit_hh  = (win == PAT_HH);
   assign hit_hq  = (win == PAT_HQ);
   assign hit_any = hit_sf | hit_hh | hit_hq;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q  <= '0;
         aligned  <= 1'b0;
         sym_stb  <= 1'b0;
         pair_stb <= 1'b0;
         sof      <= 1'b0;
         hh       <= 1'b0;
         hq       <= 1'b0;
         code     <= '0;
      end else begin
         sym_stb  <= 1'b0;
         pair_stb <= 1'b0;
         sof      <= 1'b0;
         hh       <= 1'b0;
         hq       <= 1'b0;
         if (fresh) begin
            sof <= hit_sf;
            hh  <= hit_hh;
            hq  <= hit_hq;
            if (hit_any) begin
               aligned  <= 1'b1;
               phase_q  <= '0;
               sym_stb  <= 1'b1;
               pair_stb <= 1'b1;
               code     <= win[SYM_W-1:0];
            end else if (aligned) begin
               if (phase_q == CNT_W'(PAIR_W - 1)) begin
                  phase_q  <= '0;
                  sym_stb  <= 1'b1;
                  pair_stb <= 1'b1;
                  code     <= win[SYM_W-1:0];
               end else begin
                  phase_q <= phase_q + 1'b1;
                  if (phase_q == CNT_W'(SYM_W - 1)) begin
                     sym_stb <= 1'b1;
                     code    <= win[SYM_W-1:0];
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/sym_frame_rx.sv
module sym_frame_rx #(
   parameter int SYM_W        = 5,
   parameter bit LINE_CODE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bit_en,
   input  logic             line_bit,
   input  logic             loop_bit,
   input  logic             loop_sel,
   input  logic             nrz_bypass,
   output logic             sym_valid,
   output logic             pair_strobe,
   output logic [SYM_W-1:0] sym_code,
   output logic [SYM_W-2:0] sym_data,
   output logic             sym_is_data,
   output logic             sym_ctrl,
   output logic             aligned,
   output logic             sof_pulse,
   output logic             hh_pulse,
   output logic             hq_pulse
);
   import sfr_pkg::*;

   localparam int PAIR_W = 2 * SYM_W;
   localparam int DATA_W = SYM_W - 1;

   if (SYM_W != 5) begin : g_bad_width
      $error("sym_frame_rx: the 4B/5B decode needs SYM_W == 5");
   end

   logic              nrz_bit;
   logic [PAIR_W-1:0] win;
   logic              fresh;
   sym_dec_t          dec;

   sfr_line_stage #(.LINE_CODE_EN(LINE_CODE_EN)) u_line (
      .clk(clk), .rst(rst), .bit_en(bit_en), .line_bit(line_bit),
      .loop_bit(loop_bit), .loop_sel(loop_sel), .nrz_bypass(nrz_bypass),
      .nrz_bit(nrz_bit)
   );

   sfr_window #(.W(PAIR_W)) u_win (
      .clk(clk), .rst(rst), .shift_en(bit_en), .din(nrz_bit),
      .win_q(win), .fresh_q(fresh)
   );

   sfr_framer #(.SYM_W(SYM_W)) u_frm (
      .clk(clk), .rst(rst), .fresh(fresh), .win(win),
      .sym_stb(sym_valid), .pair_stb(pair_strobe), .aligned(aligned),
      .sof(sof_pulse), .hh(hh_pulse), .hq(hq_pulse), .code(sym_code)
   );

   assign dec         = decode_5b(sym_code);
   assign sym_data    = dec.is_data ? DATA_W'(dec.value) : '0;
   assign sym_is_data = sym_valid & dec.is_data;
   assign sym_ctrl    = sym_valid & ~dec.is_data;
endmodule

// File: rtl/sfr_rx_checker.sv
module sfr_rx_checker (
   input logic clk,
   input logic rst,
   input logic bit_en,
   input logic sym_valid,
   input logic pair_strobe,
   input logic aligned,
   input logic sof_pulse,
   input logic hh_pulse,
   input logic hq_pulse,
   input logic sym_is_data,
   input logic sym_ctrl
);
   AST_STROBE_WHEN_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      sym_valid |-> aligned) else $error("strobe while unaligned"); // R9
   AST_PAIR_ON_SYMBOL: assert property (@(posedge clk) disable iff (rst)
      pair_strobe |-> sym_valid) else $error("pair without symbol"); // R10
   AST_SOF_ALIGNS: assert property (@(posedge clk) disable iff (rst)
      sof_pulse |-> (aligned && pair_strobe)) else $error("sof not aligning"); // R6
   AST_HH_ALIGNS: assert property (@(posedge clk) disable iff (rst)
      hh_pulse |-> (aligned && pair_strobe)) else $error("hh not aligning"); // R7
   AST_HQ_ALIGNS: assert property (@(posedge clk) disable iff (rst)
      hq_pulse |-> (aligned && pair_strobe)) else $error("hq not aligning"); // R8
   AST_ONE_DETECT: assert property (@(posedge clk) disable iff (rst)
      $onehot0({sof_pulse, hh_pulse, hq_pulse})) else $error("two detects"); // R6
   AST_SOF_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
      sof_pulse |=> !sof_pulse) else $error("sof held"); // R5
   AST_STROBE_AFTER_BIT: assert property (@(posedge clk) disable iff (rst)
      sym_valid |-> $past(bit_en, 2)) else $error("strobe without bit"); // R5
   AST_DATA_OR_CTRL: assert property (@(posedge clk) disable iff (rst)
      sym_valid |-> (sym_is_data != sym_ctrl)) else $error("class"); // R12
   AST_CLASS_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
      !sym_valid |-> !(sym_is_data || sym_ctrl)) else $error("class idle"); // R12
endmodule

bind sym_frame_rx sfr_rx_checker u_chk (
   .clk(clk), .rst(rst), .bit_en(bit_en), .sym_valid(sym_valid),
   .pair_strobe(pair_strobe), .aligned(aligned), .sof_pulse(sof_pulse),
   .hh_pulse(hh_pulse), .hq_pulse(hq_pulse), .sym_is_data(sym_is_data),
   .sym_ctrl(sym_ctrl)
);

// File: tb/sym_frame_rx_tb.sv
module sym_frame_rx_tb;
   localparam int CLK_P = 8;

   logic clk = 1'b0;
   logic rst, bit_en, line_bit, loop_bit, loop_sel, nrz_bypass;
   logic sym_valid, pair_strobe, sym_is_data, sym_ctrl, aligned;
   logic sof_pulse, hh_pulse, hq_pulse;
   logic [4:0] sym_code;
   logic [3:0] sym_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   sym_frame_rx u_dut (
      .clk(clk), .rst(rst), .bit_en(bit_en), .line_bit(line_bit),
      .loop_bit(loop_bit), .loop_sel(loop_sel), .nrz_bypass(nrz_bypass),
      .sym_valid(sym_valid), .pair_strobe(pair_strobe), .sym_code(sym_code),
      .sym_data(sym_data), .sym_is_data(sym_is_data), .sym_ctrl(sym_ctrl),
      .aligned(aligned), .sof_pulse(sof_pulse), .hh_pulse(hh_pulse),
      .hq_pulse(hq_pulse)
   );

   always #(CLK_P/2) clk = ~clk;

   // R12 table: index is the data value
   logic [4:0] tbl [16];
   initial begin
      tbl[0]=5'b11110; tbl[1]=5'b01001; tbl[2]=5'b10100; tbl[3]=5'b10101;
      tbl[4]=5'b01010; tbl[5]=5'b01011; tbl[6]=5'b01110; tbl[7]=5'b01111;
      tbl[8]=5'b10010; tbl[9]=5'b10011; tbl[10]=5'b10110; tbl[11]=5'b10111;
      tbl[12]=5'b11010; tbl[13]=5'b11011; tbl[14]=5'b11100; tbl[15]=5'b11101;
   end

   // bench model state
   logic [9:0] m_hist;
   int         m_phase;
   bit         m_al, m_sym, m_pair, m_sf, m_hh, m_hq;
   logic       tx_level;
   logic       junk;
   int         sof_count;
   string      mode_tag;

   logic stream [0:399];
   int   slen;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic push5(input logic [4:0] c);
      for (int i = 4; i >= 0; i--) begin
         stream[slen] = c[i];
         slen++;
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; bit_en = 1'b0; line_bit = 1'b0; loop_bit = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_hist = '0; m_phase = 0; m_al = 0; tx_level = 1'b0; junk = 1'b0;
      sof_count = 0;
   endtask

   task automatic model_bit(input logic b);
      m_hist = {m_hist[8:0], b};
      m_sf = (m_hist == 10'b11000_10001);
      m_hh = (m_hist == 10'b00100_00100);
      m_hq = (m_hist == 10'b00100_00000);
      m_sym = 0; m_pair = 0;
      if (m_sf || m_hh || m_hq) begin
         m_al = 1; m_phase = 0; m_sym = 1; m_pair = 1;
      end else if (m_al) begin
         m_phase++;
         if (m_phase == 5) m_sym = 1;
         if (m_phase == 10) begin m_sym = 1; m_pair = 1; m_phase = 0; end
      end
   endtask

   task automatic send_nrz(input logic b);
      logic wire_bit;
      if (nrz_bypass) wire_bit = b;
      else begin tx_level = tx_level ^ b; wire_bit = tx_level; end
      if (loop_sel) begin
         loop_bit = wire_bit; junk = ~junk; line_bit = junk;
      end else begin
         line_bit = wire_bit; loop_bit = ~wire_bit;
      end
      bit_en = 1'b1;
      @(posedge clk); @(negedge clk);
      bit_en = 1'b0;
      check("R5 strobe before latency", int'(sym_valid | sof_pulse | hh_pulse | hq_pulse), 0);
      model_bit(b);
      @(posedge clk); @(negedge clk);
      check("R10 symbol strobe", int'(sym_valid), int'(m_sym));
      check("R10 pair strobe", int'(pair_strobe), int'(m_pair));
      check("R9 aligned flag", int'(aligned), int'(m_al));
      check("R6 frame start", int'(sof_pulse), int'(m_sf));
      check("R7 halt-halt", int'(hh_pulse), int'(m_hh));
      check("R8 halt-quiet", int'(hq_pulse), int'(m_hq));
      if (sof_pulse) sof_count++;
      if (m_sym) begin
         int exp_d = -1;
         check(mode_tag, int'(sym_code), int'(m_hist[4:0]));
         for (int k = 0; k < 16; k++) if (tbl[k] == m_hist[4:0]) exp_d = k;
         check("R12 data flag", int'(sym_is_data), int'(exp_d >= 0));
         check("R12 ctrl flag", int'(sym_ctrl), int'(exp_d < 0));
         check("R12 data value", int'(sym_data), (exp_d >= 0) ? exp_d : 0);
      end
   endtask

   task automatic build_stream();
      slen = 0;
      for (int i = 0; i < 7; i++) begin stream[slen] = logic'(i % 3 == 0); slen++; end
      push5(5'b11000); push5(5'b10001);
      for (int k = 0; k < 16; k++) push5(tbl[k]);
      push5(5'b00111); push5(5'b11111);
      push5(5'b00100); push5(5'b00100);
      push5(5'b00100); push5(5'b00000);
      // R11: three extra bits move the next frame start off the old phase
      stream[slen] = 1'b1; stream[slen+1] = 1'b0; stream[slen+2] = 1'b1; slen += 3;
      push5(5'b11000); push5(5'b10001);
      push5(tbl[5]); push5(tbl[10]); push5(5'b00111); push5(5'b11111);
   endtask

   task automatic run_stream(input bit byp, input bit lsel, input string tag);
      nrz_bypass = byp; loop_sel = lsel; mode_tag = tag;
      do_reset();
      check("R1 aligned after reset", int'(aligned), 0);
      check("R1 strobes after reset",
            int'(sym_valid | pair_strobe | sof_pulse | hh_pulse | hq_pulse), 0);
      for (int i = 0; i < slen; i++) send_nrz(stream[i]);
      check("R11 two frame starts", sof_count, 2);
   endtask

   initial begin
      rst = 1'b1; bit_en = 1'b0; line_bit = 1'b0; loop_bit = 1'b0;
      loop_sel = 1'b0; nrz_bypass = 1'b0;
      build_stream();
      run_stream(1'b0, 1'b0, "R2 NRZI symbol code");
      run_stream(1'b1, 1'b0, "R3 NRZ symbol code");
      run_stream(1'b0, 1'b1, "R4 loopback symbol code");

      // R5 back-to-back burst in NRZ mode
      begin
         logic [4:0] bcodes [8];
         int n_sym = 0, n_pair = 0, n_sof = 0;
         bcodes[0] = 5'b11000; bcodes[1] = 5'b10001;
         for (int k = 0; k < 6; k++) bcodes[k+2] = tbl[k];
         nrz_bypass = 1'b1; loop_sel = 1'b0;
         do_reset();
         for (int s = 0; s < 8; s++) begin
            for (int i = 4; i >= 0; i--) begin
               n_sym  += int'(sym_valid);
               n_pair += int'(pair_strobe);
               n_sof  += int'(sof_pulse);
               line_bit = bcodes[s][i]; bit_en = 1'b1;
               @(negedge clk);
            end
         end
         bit_en = 1'b0;
         for (int c = 0; c < 4; c++) begin
            n_sym  += int'(sym_valid);
            n_pair += int'(pair_strobe);
            n_sof  += int'(sof_pulse);
            @(negedge clk);
         end
         check("R5 burst symbol strobes", n_sym, 7);
         check("R5 burst pair strobes", n_pair, 4);
         check("R6 burst frame start", n_sof, 1);
         check("R10 burst last code", int'(sym_code), int'(tbl[5]));
      end

      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         done = 1;
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule